// File: doc/BRIEF.md
# Three-Level Bipolar Pulse Sequencer

This block is the digital control for a stacked full-bridge high-voltage transmit pulser. A fire strobe starts a transmit event. The block first waits a programmed number of clock ticks, which sets the per-channel transmit delay. It then plays a burst of bipolar pulses. Each pulse period has four phases in a fixed order: positive drive, short, negative drive, short. During a short phase both transducer terminals are tied together, so the stored charge is shared instead of being dumped to ground.

At a 60 MHz clock the pulse rate is 7.5 MHz. One period is therefore 8 clocks, and each phase is 2 clocks. The first clock of each short phase is a guard clock in which all bridge devices are off. No device can turn on while a drive-side device is still conducting. A transmit enable frames the running burst so that the pulser clock can be gated off outside it. The transmit switch enable follows the first phase input.

Top module: `tx3l_pulse_seq`

## Requirements
- R1: After reset, and until a burst starts, `tx_en`, `txin1`, `txin2`, `txsw_en` and all bits of `cont` are 0.
- R2: A fire strobe is captured at a clock edge. The drive pattern of the first pulse appears D+1 clocks after that edge, where D is the `tx_delay` value captured with the strobe. Between the capture and that point, every output is 0.
- R3: A running burst repeats an 8-clock period, counted from its first clock. The steps are: positive drive on steps 0 and 1, guard on step 2, short on step 3, negative drive on steps 4 and 5, guard on step 6, short on step 7.
- R4: The phase inputs encode the drive state as {txin1,txin2}: positive drive = 10, negative drive = 01, short = 11, guard or idle = 00.
- R5: Bridge control bits are assigned as follows. `cont[0]` is the positive-terminal high side, `cont[1]` the positive-terminal low side, `cont[2]` the negative-terminal high side and `cont[3]` the negative-terminal low side. `cont[7:4]` are the four middle shorting devices. Positive drive gives 8'h09, negative drive 8'h06, short 8'hF0, and all other states 8'h00. The high and low devices of one leg are never on together.
- R6: A drive step is never directly followed by a short step. Exactly one all-off guard clock, with `tx_en` still 1, lies between them.
- R7: `txsw_en` equals `txin1` on every clock.
- R8: `tx_en` is 1 for exactly 8·N consecutive clocks, where N is the `burst_len` value captured with the strobe. It is 0 during the delay wait.
- R9: The last clock of a burst is a short step. On the next clock every output is 0.
- R10: A fire strobe that arrives while a delay wait or a burst is in progress is ignored. It neither restarts nor lengthens the current event, and it starts no new one.
- R11: A fire strobe with `burst_len` equal to 0 is ignored, and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock, 60 MHz nominal |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| fire | input | 1 | Start strobe, sampled on the rising clock edge |
| tx_delay | input | DLY_W | Start delay in clock ticks, captured with the strobe |
| burst_len | input | LEN_W | Number of pulse periods, captured with the strobe |
| txin1 | output | 1 | Phase input one of the pulser |
| txin2 | output | 1 | Phase input two of the pulser |
| tx_en | output | 1 | Burst frame; pulser clock enable |
| cont | output | 8 | Full-bridge device controls |
| txsw_en | output | 1 | Transmit switch enable |

## Verification
Some properties are checked by assertions on every cycle. These are: the legs are mutually exclusive, and no drive bit is on together with a shorting bit. A guard clock always separates a drive step from a short step. Every burst ends on a short step. Everything is quiet outside `tx_en`. The delay counter steps down by one per clock, and a strobe during a burst never arms a new delay. Other behaviour can only be shown by the bench's scenarios. This covers the exact latency from strobe to first pulse and the exact number of periods. It also covers the step-by-step waveform against the encoding tables, and that strobes at chosen points are ignored: during the wait, mid-burst, on the final clock, and with a zero length.

// File: rtl/tx3l_pkg.sv
package tx3l_pkg;

  typedef enum logic [1:0] {
    DRV_OFF   = 2'b00,
    DRV_NEG   = 2'b01,
    DRV_POS   = 2'b10,
    DRV_SHORT = 2'b11
  } drive_t;

  // Map a step inside one pulse period to a drive state.
  // Phases: 0 positive, 1 share, 2 negative, 3 share.
  // The first clock of a share phase is the all-off guard.
  function automatic drive_t tx3l_drive_of(input int step, input int ph_clks);
    int phase;
    int sub;
    phase = step / ph_clks;
    sub   = step % ph_clks;
    case (phase)
      0:       tx3l_drive_of = DRV_POS;
      2:       tx3l_drive_of = DRV_NEG;
      default: tx3l_drive_of = (sub == 0) ? DRV_OFF : DRV_SHORT;
    endcase
  endfunction

  // Bridge device selection from the two phase inputs.
  // bit0 P-high, bit1 P-low, bit2 N-high, bit3 N-low, bits7:4 middle shorts.
  function automatic logic [7:0] tx3l_bridge(input logic p1, input logic p2);
    case ({p1, p2})
      2'b10:   tx3l_bridge = 8'h09;
      2'b01:   tx3l_bridge = 8'h06;
      2'b11:   tx3l_bridge = 8'hF0;
      default: tx3l_bridge = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/tx3l_delay_ctr.sv
module tx3l_delay_ctr #(
  parameter int DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             armed,
  output logic             go
);

  logic [DLY_W-1:0] cnt_q;

  assign go = armed && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt_q <= '0;
    end else if (load) begin
      armed <= 1'b1;
      cnt_q <= load_val;
    end else if (go) begin
      armed <= 1'b0;
    end else if (armed) begin
      cnt_q <= cnt_q - DLY_W'(1);
    end
  end

  // R2: while waiting, the count steps down by exactly one each clock
  assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !go && !load) |=> (cnt_q == $past(cnt_q) - DLY_W'(1)));

endmodule

// File: rtl/tx3l_phase_seq.sv
module tx3l_phase_seq
  import tx3l_pkg::*;
#(
  parameter int LEN_W   = 6,
  parameter int PH_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic             start,
  output logic             active,
  output drive_t           drive,
  output logic             last_step
);

  localparam int PERIOD = 4 * PH_CLKS;
  localparam int STEP_W = $clog2(PERIOD);

  logic [STEP_W-1:0] step_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  left_q;
  logic              period_end;

  assign period_end = (int'(step_q) == PERIOD - 1);
  assign last_step  = active && period_end && (left_q == '0);
  assign drive      = active ? tx3l_drive_of(int'(step_q), PH_CLKS) : DRV_OFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      step_q <= '0;
      len_q  <= '0;
      left_q <= '0;
    end else begin
      if (load) len_q <= load_len;
      if (start) begin
        active <= 1'b1;
        step_q <= '0;
        left_q <= len_q - LEN_W'(1);
      end else if (active) begin
        if (period_end) begin
          step_q <= '0;
          if (left_q == '0) active <= 1'b0;
          else              left_q <= left_q - LEN_W'(1);
        end else begin
          step_q <= step_q + STEP_W'(1);
        end
      end
    end
  end

  // R6: a drive step is never followed straight by a short step
  assert_guard_before_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drive == DRV_POS || drive == DRV_NEG) |=> (drive != DRV_SHORT));

  // R9: a burst always ends from a short step
  assert_ends_on_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> ($past(drive) == DRV_SHORT));

  // R8: the remaining-period count never exceeds the captured length
  assert_left_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (left_q < len_q));

endmodule

// File: rtl/tx3l_bridge_dec.sv
module tx3l_bridge_dec
  import tx3l_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       p1,
  input  logic       p2,
  output logic [7:0] cont
);

  assign cont = tx3l_bridge(p1, p2);

  // R5: high and low devices of a leg never conduct together
  assert_leg_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cont[0] && cont[1]) && !(cont[2] && cont[3]));

  // R5: no drive device is on together with a shorting device
  assert_drive_vs_short_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|cont[3:0]) |-> (cont[7:4] == 4'h0));

endmodule

// File: rtl/tx3l_pulse_seq.sv
module tx3l_pulse_seq
  import tx3l_pkg::*;
#(
  parameter int DLY_W   = 10,
  parameter int LEN_W   = 6,
  parameter int PH_CLKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [DLY_W-1:0] tx_delay,
  input  logic [LEN_W-1:0] burst_len,
  output logic             txin1,
  output logic             txin2,
  output logic             tx_en,
  output logic [7:0]       cont,
  output logic             txsw_en
);

  logic   dly_armed;
  logic   dly_go;
  logic   seq_active;
  logic   seq_last;
  logic   busy;
  logic   accept;
  drive_t drive;

  assign busy   = dly_armed || seq_active;
  assign accept = fire && !busy && (burst_len != '0);

  tx3l_delay_ctr #(.DLY_W(DLY_W)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (tx_delay),
    .armed    (dly_armed),
    .go       (dly_go)
  );

  tx3l_phase_seq #(.LEN_W(LEN_W), .PH_CLKS(PH_CLKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_len  (burst_len),
    .start     (dly_go),
    .active    (seq_active),
    .drive     (drive),
    .last_step (seq_last)
  );

  assign txin1   = drive[1];
  assign txin2   = drive[0];
  assign tx_en   = seq_active;
  assign txsw_en = txin1;

  tx3l_bridge_dec u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .p1    (txin1),
    .p2    (txin2),
    .cont  (cont)
  );

  // R1 R8: outside the burst frame every drive output is quiet
  assert_quiet_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> (cont == 8'h00 && !txin1 && !txin2 && !txsw_en));

  // R10: a strobe during a burst never arms a new delay
  assert_fire_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && fire) |=> !dly_armed);

  // R2: a burst only starts out of a completed delay wait
  assert_start_after_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(dly_go));

  // R9: the final step event is seen just before the frame drops
  assert_last_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_last |=> !tx_en);

endmodule

// File: tb/sim_tx3l_pulse_seq.sv
module sim_tx3l_pulse_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fire = 1'b0;
  logic [9:0] tx_delay = '0;
  logic [5:0] burst_len = '0;
  logic       txin1, txin2, tx_en, txsw_en;
  logic [7:0] cont;

  int n_cmp = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tx3l_pulse_seq u0 (
    .clk(clk), .rst_n(rst_n), .fire(fire), .tx_delay(tx_delay),
    .burst_len(burst_len), .txin1(txin1), .txin2(txin2), .tx_en(tx_en),
    .cont(cont), .txsw_en(txsw_en)
  );

  function automatic logic [11:0] obs();
    return {tx_en, txin1, txin2, txsw_en, cont};
  endfunction

  // expected {tx_en, txin1, txin2, txsw_en, cont} for burst step s
  function automatic logic [11:0] exp_step(input int s);
    case (s % 8)
      0, 1:    return {1'b1, 2'b10, 1'b1, 8'h09};
      4, 5:    return {1'b1, 2'b01, 1'b0, 8'h06};
      3, 7:    return {1'b1, 2'b11, 1'b1, 8'hF0};
      default: return {1'b1, 2'b00, 1'b0, 8'h00};
    endcase
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // One burst with an optional extra strobe at sample ign_j (-1 = none).
  task automatic run_burst(input int d, input int n, input int ign_j);
    int en_cnt = 0;
    int last_j = d + 8 * n + 2;
    @(negedge clk);
    fire = 1'b1; tx_delay = 10'(d); burst_len = 6'(n);
    @(posedge clk);
    @(negedge clk);
    fire = 1'b0;
    check("R2 capture", obs(), 12'h000);
    for (int j = 1; j <= last_j; j++) begin
      @(negedge clk);
      if (j <= d) check("R2 wait", obs(), 12'h000);
      else if (j <= d + 8 * n) begin
        int s = j - d - 1;
        if (s % 4 == 2) check("R6 guard", obs(), exp_step(s));
        else            check("R3 R4 R5 step", obs(), exp_step(s));
        check("R7 switch", {11'b0, txsw_en}, {11'b0, txin1});
      end else check("R9 after end", obs(), 12'h000);
      if (tx_en) en_cnt++;
      if (j == ign_j) begin
        fire = 1'b1; tx_delay = 10'd0; burst_len = 6'd5;
      end else if (j == ign_j + 1) begin
        fire = 1'b0;
      end
    end
    fire = 1'b0;
    check("R8 frame length", 12'(en_cnt), 12'(8 * n));
  endtask

  task automatic test_reset();
    @(negedge clk);
    check("R1 reset", obs(), 12'h000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle", obs(), 12'h000);
  endtask

  task automatic test_zero_len();
    @(negedge clk);
    fire = 1'b1; tx_delay = 10'd0; burst_len = 6'd0;
    @(negedge clk);
    fire = 1'b0;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      check("R11 zero length", obs(), 12'h000);
    end
  endtask

  initial begin
    test_reset();
    run_burst(0, 1, -1);
    run_burst(4, 2, 2);      // R10 strobe during wait
    run_burst(2, 2, 9);      // R10 strobe mid burst
    run_burst(1, 3, 25);     // R10 strobe on final clock
    test_zero_len();
    run_burst(0, 2, -1);     // R11 normal strobe accepted after ignored one
    run_burst(200, 1, 100);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

endmodule